// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave (1 KiB)

This block is a two-wire bus slave that holds a 1024-byte array. Both bus lines arrive as plain inputs and are oversampled by the system clock. START and STOP conditions are found by watching for SDA transitions while SCL is high. The slave's only drive onto the bus is a pull-low enable, `sda_pull`. Outside the block, the line is modelled as wired-AND: `sda = master_sda & ~sda_pull`.

A command opens with a device byte, sent most significant bit first:

- bits 7:4 are the fixed pattern 1010;
- bit 3 must equal the strap input `sel_pin`;
- bits 2:1 are memory address bits 9:8;
- bit 0 chooses read (1) or write (0).

A write command then takes a word-address byte holding address bits 7:0, followed by one data byte. A read command returns bytes from an internal address pointer.

A repeated START placed after the word-address byte turns a write setup into a random read. The `wp` strap protects the whole array. After each stored byte, a write-cycle timer of `WR_CYCLES` clocks keeps the device busy.

The block has no streaming interface. The bus is the only data path, and it has no back-pressure beyond the acknowledge bit. The straps `sel_pin` and `wp` and the flags `busy` and `standby` are plain level signals.

Top module: `twi_eeprom`

## Requirements
- R1: After reset, `sda_pull`, `busy` and `standby` are all 0.
- R2: A falling SDA while SCL is high is a START, and a rising SDA while SCL is high is a STOP. Clocked bits that arrive before any START, or after a STOP, are never acknowledged.
- R3: The slave acknowledges a device byte by holding `sda_pull` high through the ninth clock. To be acknowledged, bits 7:4 must be 1010 and bit 3 must equal `sel_pin`; bits 2:1 carry address 9:8 and bit 0 is read (1) or write (0).
- R4: If the device byte does not match, SDA stays released for the rest of that command. Later bytes are not acknowledged until the next START.
- R5: A byte write is device byte (write), then word-address byte, then data byte. All three are acknowledged, and the data is stored at {device bits 2:1, word byte}.
- R6: When `wp` is 1, the data byte is still acknowledged but the array is unchanged, and no write cycle starts (`busy` stays 0).
- R7: A stored byte raises `busy` for exactly `WR_CYCLES` clock cycles. While `busy` is 1, a device byte is not acknowledged.
- R8: Device byte (write), then word-address byte, then a repeated START and device byte (read), returns the addressed byte MSB first. Each bit changes only after SCL falls.
- R9: The internal pointer advances by one after each byte that is stored or sent, and wraps from 1023 to 0. A read with no word address returns the byte at the pointer.
- R10: A master NACK ends the read and the slave releases SDA. A STOP that ends a read sets `standby`; the next START clears it.
- R11: `sda_pull` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin (wired value) |
| sda_pull | output | 1 | 1 pulls the data line low |
| sel_pin | input | 1 | Strap compared against device byte bit 3 |
| wp | input | 1 | 1 protects the whole array against writes |
| busy | output | 1 | Internal write cycle in progress |
| standby | output | 1 | Set by a STOP that ended a read |

## Verification
A bus edge takes two synchroniser flops and one edge flop to reach the controller, so `sda_pull` moves on the third clock after SCL falls. The bench holds every SCL phase for six clocks, samples on the falling clock edge, and reads acknowledge and data bits mid-way through SCL high, well after that latency. `busy` rises two clocks after the eighth data bit is registered. Its width is measured edge by edge against `WR_CYCLES`, and `standby` is checked once the STOP or START that moves it has finished.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam int ADDR_W = 10;
  localparam logic [3:0] DEV_PREFIX = 4'b1010;

  typedef enum logic [2:0] {
    PH_IDLE, PH_RX, PH_ACK, PH_TX, PH_MACK, PH_WAIT
  } phase_e;

  typedef enum logic [1:0] {
    K_DEV, K_WORD, K_DATA
  } kind_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  localparam int LINES = 2;
  logic [LINES-1:0] raw;
  logic [LINES-1:0] synced;
  logic [LINES-1:0] prev;

  assign raw = {scl, sda};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '1;
    else        prev <= synced;
  end

  assign sda_s     = synced[0];
  assign scl_rise  = synced[1] & ~prev[1];
  assign scl_fall  = ~synced[1] & prev[1];
  assign start_evt = synced[1] & prev[1] & prev[0] & ~synced[0];
  assign stop_evt  = synced[1] & prev[1] & ~prev[0] & synced[0];
endmodule

// File: rtl/twi_wr_timer.sv
module twi_wr_timer #(
  parameter int WR_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic busy
);
  localparam int CW = $clog2(WR_CYCLES + 1);
  logic [CW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            left <= '0;
    else if (kick)         left <= CW'(WR_CYCLES);
    else if (left != '0)   left <= left - 1'b1;
  end

  assign busy = (left != '0);
endmodule

// File: rtl/twi_mem_array.sv
module twi_mem_array #(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/twi_eeprom.sv
module twi_eeprom #(
  parameter int WR_CYCLES   = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_pull,
  input  logic sel_pin,
  input  logic wp,
  output logic busy,
  output logic standby
);
  import twi_pkg::*;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAGE_W = ADDR_W - 8;

  logic sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  phase_e phase;
  kind_e  kind;
  logic [2:0] cnt;
  logic [6:0] sr;
  logic [6:0] tx;
  logic [ADDR_W-1:0] ptr;
  logic [PAGE_W-1:0] page;
  logic rd_cmd, ack_live, mack_seen;
  logic wr_req;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0] wr_data, rdata, byte_in;

  twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl(scl_in), .sda(sda_in),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  twi_wr_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .kick(wr_req), .busy(busy)
  );

  twi_mem_array #(.DEPTH(DEPTH), .AW(ADDR_W)) u_mem (
    .clk(clk), .we(wr_req), .waddr(wr_addr), .wdata(wr_data),
    .raddr(ptr), .rdata(rdata)
  );

  assign byte_in = {sr, sda_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      kind      <= K_DEV;
      cnt       <= '0;
      sr        <= '0;
      tx        <= '0;
      ptr       <= '0;
      page      <= '0;
      rd_cmd    <= 1'b0;
      ack_live  <= 1'b0;
      mack_seen <= 1'b0;
      sda_pull  <= 1'b0;
      standby   <= 1'b0;
      wr_req    <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      wr_req <= 1'b0;
      if (start_evt) begin
        phase    <= PH_RX;
        kind     <= K_DEV;
        cnt      <= '0;
        sda_pull <= 1'b0;
        ack_live <= 1'b0;
        standby  <= 1'b0;
      end else if (stop_evt) begin
        phase    <= PH_IDLE;
        sda_pull <= 1'b0;
        ack_live <= 1'b0;
        if (rd_cmd) standby <= 1'b1;
        rd_cmd   <= 1'b0;
      end else begin
        case (phase)
          PH_RX: if (scl_rise) begin
            sr  <= {sr[5:0], sda_s};
            cnt <= cnt + 1'b1;
            if (cnt == 3'd7) begin
              case (kind)
                K_DEV: begin
                  if (byte_in[7:4] == DEV_PREFIX && byte_in[3] == sel_pin && !busy) begin
                    phase  <= PH_ACK;
                    rd_cmd <= byte_in[0];
                    if (!byte_in[0]) page <= byte_in[2:1];
                  end else begin
                    phase <= PH_WAIT;
                  end
                end
                K_WORD: begin
                  ptr   <= {page, byte_in};
                  phase <= PH_ACK;
                end
                K_DATA: begin
                  wr_req  <= !wp;
                  wr_addr <= ptr;
                  wr_data <= byte_in;
                  ptr     <= ptr + 1'b1;
                  phase   <= PH_ACK;
                end
                default: phase <= PH_WAIT;
              endcase
            end
          end
          PH_ACK: if (scl_fall) begin
            if (!ack_live) begin
              sda_pull <= 1'b1;
              ack_live <= 1'b1;
            end else begin
              ack_live <= 1'b0;
              sda_pull <= 1'b0;
              cnt      <= '0;
              case (kind)
                K_DEV: begin
                  if (rd_cmd) begin
                    tx       <= rdata[6:0];
                    sda_pull <= ~rdata[7];
                    ptr      <= ptr + 1'b1;
                    phase    <= PH_TX;
                  end else begin
                    kind  <= K_WORD;
                    phase <= PH_RX;
                  end
                end
                K_WORD: begin
                  kind  <= K_DATA;
                  phase <= PH_RX;
                end
                default: phase <= PH_WAIT;
              endcase
            end
          end
          PH_TX: if (scl_fall) begin
            if (cnt == 3'd7) begin
              sda_pull  <= 1'b0;
              mack_seen <= 1'b0;
              phase     <= PH_MACK;
            end else begin
              cnt      <= cnt + 1'b1;
              sda_pull <= ~tx[3'd6 - cnt];
            end
          end
          PH_MACK: begin
            if (scl_rise) begin
              if (sda_s) phase <= PH_WAIT;
              else       mack_seen <= 1'b1;
            end else if (scl_fall && mack_seen) begin
              tx       <= rdata[6:0];
              sda_pull <= ~rdata[7];
              ptr      <= ptr + 1'b1;
              cnt      <= '0;
              phase    <= PH_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/twi_eeprom_chk.sv
module twi_eeprom_chk #(
  parameter int WR_CYCLES = 2000
) (
  input logic clk,
  input logic rst_n,
  input logic scl_in,
  input logic sda_pull,
  input logic busy,
  input logic wp,
  input logic standby,
  input logic start_evt,
  input logic stop_evt
);
  localparam int RW = $clog2(WR_CYCLES + 2);
  logic [RW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run <= '0;
    else if (busy) run <= (run == RW'(WR_CYCLES + 1)) ? run : run + 1'b1;
    else           run <= '0;
  end

  a_r11_pull_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull != $past(sda_pull)) |-> !scl_in);

  a_r10_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_pull);

  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (!sda_pull && !standby));

  a_r10_standby_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(standby) |-> $past(stop_evt));

  a_r6_no_cycle_when_protected: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !wp);

  a_r7_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    run <= RW'(WR_CYCLES));
endmodule

bind twi_eeprom twi_eeprom_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_pull(sda_pull),
  .busy(busy), .wp(wp), .standby(standby),
  .start_evt(start_evt), .stop_evt(stop_evt)
);

// File: tb/test_twi_eeprom.sv
module test_twi_eeprom;
  localparam int WRC = 400;
  localparam int Q   = 6;
  localparam logic SEL = 1'b1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic wp = 1'b0;
  logic sda_pull, busy, standby;
  wire  sda_line = sda_m & ~sda_pull;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  int run_len = 0, last_len = 0;
  logic [7:0] ref_mem [1024];
  bit ref_val [1024];

  always #2.5 clk = ~clk;

  twi_eeprom #(.WR_CYCLES(WRC)) i_twi_eeprom (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .sda_pull(sda_pull), .sel_pin(SEL), .wp(wp), .busy(busy), .standby(standby)
  );

  always @(negedge clk) begin
    if (busy) run_len++;
    else if (run_len != 0) begin last_len = run_len; run_len = 0; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] dev_byte(input logic sel, input logic [1:0] pg, input logic rw);
    return {4'b1010, sel, pg, rw};
  endfunction

  task automatic bus_start;
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    ack = !sda_line;
    tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl_m = 1'b1; tick(Q); b[i] = sda_line; tick(Q); scl_m = 1'b0; tick(Q);
    end
    sda_m = !mack; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic do_write(input logic [9:0] a, input logic [7:0] d, output logic [2:0] acks);
    logic k;
    acks = 3'b000;
    bus_start;
    send_byte(dev_byte(SEL, a[9:8], 1'b0), k); acks[2] = k;
    if (k) begin
      send_byte(a[7:0], k); acks[1] = k;
      send_byte(d, k); acks[0] = k;
      if (!wp) begin ref_mem[a] = d; ref_val[a] = 1'b1; end
    end
    bus_stop;
  endtask

  task automatic wait_idle;
    int k = 0;
    while (busy && k < 4*WRC) begin tick(1); k++; end
  endtask

  task automatic do_rand_read(input logic [9:0] a, input int n, output logic [15:0] got, output logic [2:0] acks);
    logic k;
    logic [7:0] b;
    got = '0;
    bus_start;
    send_byte(dev_byte(SEL, a[9:8], 1'b0), k); acks[2] = k;
    send_byte(a[7:0], k); acks[1] = k;
    bus_start;
    send_byte(dev_byte(SEL, 2'b00, 1'b1), k); acks[0] = k;
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n-1, b);
      got = {got[7:0], b};
    end
    bus_stop;
  endtask

  initial begin
    logic [2:0] acks;
    logic [15:0] got;
    logic k;
    logic [7:0] b;
    void'($urandom(32'd4711));
    for (int i = 0; i < 1024; i++) ref_val[i] = 1'b0;
    tick(4);
    chk("R1 sda_pull", sda_pull, 0);
    chk("R1 busy", busy, 0);
    chk("R1 standby", standby, 0);
    rst_n = 1'b1;
    tick(10);

    // R2: clocked bits before any START get no acknowledge
    scl_m = 1'b0; tick(Q);
    send_byte(dev_byte(SEL, 2'b00, 1'b0), k);
    chk("R2 no ack before START", k, 0);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);

    // R3 R5 R7: byte write and write cycle
    do_write(10'h155, 8'h3C, acks);
    chk("R5 write acks", acks, 3'b111);
    chk("R7 busy after write", busy, 1);
    bus_start; send_byte(dev_byte(SEL, 2'b01, 1'b0), k); bus_stop;
    chk("R7 no ack while busy", k, 0);
    wait_idle; tick(2);
    chk("R7 busy width", last_len, WRC);

    // R2: after a STOP, clocked bits still get no acknowledge
    scl_m = 1'b0; tick(Q);
    send_byte(dev_byte(SEL, 2'b00, 1'b0), k);
    chk("R2 no ack after STOP", k, 0);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);

    // R8 random read
    do_rand_read(10'h155, 1, got, acks);
    chk("R8 read acks", acks, 3'b111);
    chk("R8 random read data", got[7:0], 8'h3C);
    chk("R10 standby after read STOP", standby, 1);
    chk("R10 SDA released after NACK", sda_pull, 0);
    bus_start;
    chk("R10 standby cleared by START", standby, 0);
    bus_stop;

    // R9 wrap and pointer advance
    do_write(10'h3FF, 8'hA5, acks); wait_idle;
    do_write(10'h000, 8'h5A, acks); wait_idle;
    do_write(10'h002, 8'h11, acks); wait_idle;
    do_write(10'h001, 8'h77, acks); wait_idle;
    chk("R9 write acks", acks, 3'b111);
    bus_start; send_byte(dev_byte(SEL, 2'b11, 1'b1), k); recv_byte(1'b0, b); bus_stop;
    chk("R9 current read after write", b, 8'h11);
    do_rand_read(10'h3FF, 2, got, acks);
    chk("R9 wrap 1023 to 0", got, 16'hA55A);
    bus_start; send_byte(dev_byte(SEL, 2'b00, 1'b1), k); recv_byte(1'b0, b); bus_stop;
    chk("R9 current read after wrap", b, 8'h77);

    // R4 mismatch
    bus_start; send_byte(dev_byte(~SEL, 2'b00, 1'b0), k);
    chk("R4 select mismatch nack", k, 0);
    send_byte(8'h00, k);
    chk("R4 later byte nack", k, 0);
    chk("R4 SDA released", sda_pull, 0);
    bus_stop;
    bus_start; send_byte(8'hB0 | {4'b0, SEL, 3'b000}, k); bus_stop;
    chk("R4 prefix mismatch nack", k, 0);
    bus_start; send_byte(dev_byte(SEL, 2'b10, 1'b1), k); recv_byte(1'b0, b); bus_stop;
    chk("R4 R3 next START accepted", k, 1);

    // R6 write protect
    wp = 1'b1;
    do_write(10'h155, 8'hEE, acks);
    chk("R6 acks with wp", acks, 3'b111);
    chk("R6 no busy with wp", busy, 0);
    wp = 1'b0;
    do_rand_read(10'h155, 1, got, acks);
    chk("R6 array unchanged", got[7:0], 8'h3C);

    // Random traffic against the reference array (R5 R6 R8)
    for (int it = 0; it < 16; it++) begin
      logic [9:0] a;
      logic [7:0] d;
      a = 10'($urandom % 1024);
      d = 8'($urandom);
      wp = (($urandom % 4) == 0);
      do_write(a, d, acks);
      chk("R5 random write acks", acks, 3'b111);
      wp = 1'b0;
      wait_idle;
      if (ref_val[a]) begin
        do_rand_read(a, 1, got, acks);
        chk("R8 R6 random read", got[7:0], ref_mem[a]);
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule